// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block is the per-core reservation monitor for load-exclusive / store-exclusive (load-linked / store-conditional) pairs. A load-exclusive arms the monitor and records its physical address. A later store-exclusive is checked against that reservation and gets a pass or fail result. Only a passing store is forwarded to memory.

Coherence snoops from other agents are compared with the held address. The compare ignores the byte offset inside a cache block, so any access to the same block counts as a match. A matching snoop breaks the reservation. Breaking a reservation also posts an event into a one-bit mailbox and sends a wake-up pulse to the core. A core parked in a wait-for-event state can then resume and retry.

A separate snoop-hit notification breaks the reservation without an address compare. A saturating count of consecutive failed store-exclusives raises a livelock warning.

Top module: `excl_monitor`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising clock edge) disarms the reservation and clears the mailbox and the failure count. After reset, `stx_done`, `stx_pass`, `stx_fwd`, `evt_mailbox`, `wake_pulse` and `livelock_warn` are all 0.
- R2: A load-exclusive (`ldx_valid`) records `ldx_addr` and arms the reservation. A following store-exclusive to an address in the same block (equal address bits above log2(BLOCK_BYTES)) then passes: `stx_pass`=1.
- R3: A snoop (`snp_valid`) to the held block while the reservation is armed does three things. It disarms the reservation. It sets `evt_mailbox` in the next cycle. It raises `wake_pulse` for exactly that one cycle.
- R4: A snoop while the reservation is disarmed, or a snoop to a different block, has no effect. No wake-up is sent, the mailbox does not change, and an armed reservation stays armed.
- R5: Every store-exclusive gets its result in the cycle after the request: `stx_done`=1, with `stx_pass`=1 for success and 0 for failure. A failure is not forwarded (`stx_fwd`=0) and disarms the reservation.
- R6: A successful non-swap store-exclusive also disarms the reservation, so a second store-exclusive with no new load-exclusive fails.
- R7: A swap store (`stx_swap`=1 with `stx_valid`) always returns pass with `stx_fwd`=1. It neither checks nor changes the reservation.
- R8: `snp_hit` disarms the reservation and sets the mailbox without any address compare. It does not raise `wake_pulse`.
- R9: `evt_mailbox` stays set until `evt_consume` clears it. When a set and a consume arrive in the same cycle, the set wins.
- R10: Consecutive failed store-exclusives are counted, saturating at WARN_LIMIT+1. `livelock_warn` is 1 while the count exceeds WARN_LIMIT. Any passing store, swaps included, clears the count.
- R11: A load-exclusive that coincides with a snoop, snoop-hit or store-exclusive takes priority for the reservation, which ends up armed at the new address. The coinciding snoop or store is judged against the reservation as it stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ldx_valid | input | 1 | Load-exclusive request |
| ldx_addr | input | ADDR_W | Physical address of the load-exclusive |
| stx_valid | input | 1 | Store-exclusive or swap request |
| stx_swap | input | 1 | Request is a swap; bypasses the reservation |
| stx_addr | input | ADDR_W | Physical address of the store |
| snp_valid | input | 1 | Incoming coherence snoop |
| snp_addr | input | ADDR_W | Snoop address |
| snp_hit | input | 1 | Snoop-hit notification; breaks the reservation unconditionally |
| evt_consume | input | 1 | Wait-for-event logic consumes the mailbox event |
| stx_done | output | 1 | Store result valid, one cycle after the request |
| stx_pass | output | 1 | 1 = store succeeded, 0 = failed |
| stx_fwd | output | 1 | Store may be sent to memory |
| evt_mailbox | output | 1 | Pending event for the wait-for-event logic |
| wake_pulse | output | 1 | One-cycle core wake-up after a snoop match |
| livelock_warn | output | 1 | Consecutive store failures exceed WARN_LIMIT |

## Verification
The bench builds the monitor with ADDR_W=12, BLOCK_BYTES=16 and WARN_LIMIT=3. At these values every one of the 4096 possible snoop addresses can be swept against a held reservation. The same holds for every store address, so the block-boundary masking is checked at each offset, not at a few samples. The small threshold lets the sweeps cross the livelock boundary and the counter's saturation many times. The bench tracks the expected count arithmetically throughout.

// File: rtl/excl_mon_pkg.sv
// Package: shared types for the exclusive access reservation monitor.
// Assumes: one store request at most per cycle.
package excl_mon_pkg;

    // Classification of the store request presented this cycle.
    typedef enum logic [1:0] {
        STX_IDLE = 2'd0,
        STX_EXCL = 2'd1,
        STX_SWAP = 2'd2
    } stx_kind_e;

endpackage

// File: rtl/resv_track.sv
// Module: resv_track
// Holds the reservation (armed flag and full physical address).
// Compares snoop and store addresses at block granularity.
// Assumes: all comparisons use state from before this cycle's update.
// A load-exclusive overrides any clear in the same cycle.
module resv_track #(
    parameter int ADDR_W = 48,
    parameter int OFF_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ldx_valid,
    input  logic [ADDR_W-1:0] ldx_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_hit,
    input  logic              stx_excl,
    input  logic [ADDR_W-1:0] stx_addr,
    output logic              snoop_match,
    output logic              stx_ok
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

    logic              armed_q;
    logic [ADDR_W-1:0] held_q;
    logic              drop;

    // Block-granular compares against the held reservation.
    always_comb begin
        snoop_match = snp_valid && armed_q && ((held_q & BLK_MASK) == (snp_addr & BLK_MASK));
        stx_ok      = armed_q && ((held_q & BLK_MASK) == (stx_addr & BLK_MASK));
        drop        = snoop_match || snp_hit || stx_excl;
    end

    // Arm on load-exclusive, otherwise disarm on any breaking event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            held_q  <= '0;
        end else if (ldx_valid) begin
            armed_q <= 1'b1;
            held_q  <= ldx_addr;
        end else if (drop) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fail_counter.sv
// Module: fail_counter
// Saturating count of consecutive failed store-exclusives.
// Assumes: bump and clear are never high together.
module fail_counter #(
    parameter int WARN_LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump,
    input  logic clear,
    output logic warn
);
    localparam int              CNT_W = $clog2(WARN_LIMIT + 2);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(WARN_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM  = CNT_W'(WARN_LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Count failures up to saturation; any success restarts.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (clear)                 cnt_q <= '0;
        else if (bump && cnt_q != SAT)  cnt_q <= cnt_q + CNT_W'(1);
    end

    // Warning while the run of failures is above the limit.
    always_comb warn = (cnt_q > LIM);
endmodule

// File: rtl/evt_mailbox.sv
// Module: evt_mailbox
// Sticky event bit for wait-for-event logic and a registered wake pulse.
// Assumes: set has priority over consume.
module evt_mailbox (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic wake_req,
    input  logic consume,
    output logic mailbox,
    output logic wake
);
    // Mailbox holds until consumed; a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        mailbox <= 1'b0;
        else if (set_evt)  mailbox <= 1'b1;
        else if (consume)  mailbox <= 1'b0;
    end

    // Wake pulse lasts one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) wake <= 1'b0;
        else        wake <= wake_req;
    end
endmodule

// File: rtl/excl_monitor.sv
// Module: excl_monitor (top)
// Per-core exclusive access reservation monitor.
// Store results are registered and appear one cycle after the request.
// Assumes: BLOCK_BYTES is a power of two no larger than 2**(ADDR_W-1).
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int BLOCK_BYTES = 64,
    parameter int WARN_LIMIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ldx_valid,
    input  logic [ADDR_W-1:0] ldx_addr,
    input  logic              stx_valid,
    input  logic              stx_swap,
    input  logic [ADDR_W-1:0] stx_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_hit,
    input  logic              evt_consume,
    output logic              stx_done,
    output logic              stx_pass,
    output logic              stx_fwd,
    output logic              evt_mailbox,
    output logic              wake_pulse,
    output logic              livelock_warn
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);

    stx_kind_e kind;
    logic      snoop_match;
    logic      stx_ok;
    logic      pass_now;

    // Classify the store request.
    always_comb begin
        if (!stx_valid)    kind = STX_IDLE;
        else if (stx_swap) kind = STX_SWAP;
        else               kind = STX_EXCL;
        pass_now = (kind == STX_SWAP) || (kind == STX_EXCL && stx_ok);
    end

    resv_track #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .ldx_valid   (ldx_valid),
        .ldx_addr    (ldx_addr),
        .snp_valid   (snp_valid),
        .snp_addr    (snp_addr),
        .snp_hit     (snp_hit),
        .stx_excl    (kind == STX_EXCL),
        .stx_addr    (stx_addr),
        .snoop_match (snoop_match),
        .stx_ok      (stx_ok)
    );

    fail_counter #(.WARN_LIMIT(WARN_LIMIT)) u_fail (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (kind == STX_EXCL && !stx_ok),
        .clear (pass_now),
        .warn  (livelock_warn)
    );

    evt_mailbox u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (snoop_match || snp_hit),
        .wake_req (snoop_match),
        .consume  (evt_consume),
        .mailbox  (evt_mailbox),
        .wake     (wake_pulse)
    );

    // Register the store result; only a pass is forwarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stx_done <= 1'b0;
            stx_pass <= 1'b0;
            stx_fwd  <= 1'b0;
        end else begin
            stx_done <= (kind != STX_IDLE);
            stx_pass <= pass_now;
            stx_fwd  <= pass_now;
        end
    end
endmodule

// File: rtl/excl_monitor_chk.sv
// Module: excl_monitor_chk
// Port-level temporal checks for excl_monitor, attached by bind.
module excl_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic ldx_valid,
    input logic stx_valid,
    input logic stx_swap,
    input logic snp_valid,
    input logic snp_hit,
    input logic evt_consume,
    input logic stx_done,
    input logic stx_pass,
    input logic stx_fwd,
    input logic evt_mailbox,
    input logic wake_pulse,
    input logic livelock_warn
);
    AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stx_valid |=> stx_done); // R5
    AST_FAIL_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_done && !stx_pass) |-> !stx_fwd); // R5
    AST_SWAP_ALWAYS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_valid && stx_swap) |=> (stx_pass && stx_fwd)); // R7
    AST_WAKE_WITH_MAILBOX: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> evt_mailbox); // R3
    AST_WAKE_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(snp_valid)); // R3
    AST_HIT_SETS_MAILBOX: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hit |=> evt_mailbox); // R8
    AST_MAILBOX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mailbox && !evt_consume) |=> evt_mailbox); // R9
    AST_PASS_CLEARS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_done && stx_pass) |-> !livelock_warn); // R10
    AST_NO_RESULT_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!stx_valid) |=> !stx_done); // R5
    AST_LDX_NO_IDLE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ldx_valid && !snp_valid && !snp_hit && !evt_consume && !evt_mailbox) |=> !evt_mailbox); // R2
endmodule

bind excl_monitor excl_monitor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ldx_valid     (ldx_valid),
    .stx_valid     (stx_valid),
    .stx_swap      (stx_swap),
    .snp_valid     (snp_valid),
    .snp_hit       (snp_hit),
    .evt_consume   (evt_consume),
    .stx_done      (stx_done),
    .stx_pass      (stx_pass),
    .stx_fwd       (stx_fwd),
    .evt_mailbox   (evt_mailbox),
    .wake_pulse    (wake_pulse),
    .livelock_warn (livelock_warn)
);

// File: tb/sim_excl_monitor.sv
// Bench: sweeps snoop and store addresses over the full 12-bit space.
module sim_excl_monitor;
    localparam int AW    = 12;
    localparam int BLK   = 16;
    localparam int LIMIT = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ldx_valid, stx_valid, stx_swap, snp_valid, snp_hit, evt_consume;
    logic [AW-1:0] ldx_addr, stx_addr, snp_addr;
    logic          stx_done, stx_pass, stx_fwd, evt_mailbox, wake_pulse, livelock_warn;

    int n_chk  = 0;
    int n_fail = 0;
    int consec = 0;   // model of consecutive store-exclusive failures
    int cycles = 0;

    always #5 clk = ~clk;

    excl_monitor #(.ADDR_W(AW), .BLOCK_BYTES(BLK), .WARN_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ldx_valid(ldx_valid), .ldx_addr(ldx_addr),
        .stx_valid(stx_valid), .stx_swap(stx_swap), .stx_addr(stx_addr),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_hit(snp_hit),
        .evt_consume(evt_consume),
        .stx_done(stx_done), .stx_pass(stx_pass), .stx_fwd(stx_fwd),
        .evt_mailbox(evt_mailbox), .wake_pulse(wake_pulse),
        .livelock_warn(livelock_warn)
    );

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_in();
        ldx_valid = 0; stx_valid = 0; stx_swap = 0; snp_valid = 0;
        snp_hit = 0; evt_consume = 0;
        ldx_addr = '0; stx_addr = '0; snp_addr = '0;
    endtask

    // Clock one edge with the current inputs, then settle and release them.
    task automatic tick();
        @(posedge clk); #1;
        clr_in();
    endtask

    task automatic ldx(input int a);
        ldx_valid = 1; ldx_addr = AW'(a); tick();
    endtask

    // Store-exclusive; checks the result against the bench's expectation.
    task automatic stx(input int a, input bit exp_pass, input string req);
        stx_valid = 1; stx_addr = AW'(a); tick();
        chk(stx_done, 1, req);
        chk(stx_pass, exp_pass, req);
        chk(stx_fwd, exp_pass, req);
        consec = exp_pass ? 0 : ((consec < LIMIT + 1) ? consec + 1 : consec);
        chk(livelock_warn, (consec > LIMIT) ? 1 : 0, "R10 warn");
    endtask

    function automatic bit same_blk(input int a, input int b);
        return (a / BLK) == (b / BLK);
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        clr_in();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1;
        // R1: outputs cleared during reset
        chk(stx_done, 0, "R1 done"); chk(stx_pass, 0, "R1 pass");
        chk(stx_fwd, 0, "R1 fwd"); chk(evt_mailbox, 0, "R1 mailbox");
        chk(wake_pulse, 0, "R1 wake"); chk(livelock_warn, 0, "R1 warn");
        rst_n = 1;
        tick();

        // R4: snoop with reservation disarmed has no effect; store then fails (R5)
        snp_valid = 1; snp_addr = 12'h123; tick();
        chk(wake_pulse, 0, "R4 idle snoop wake");
        chk(evt_mailbox, 0, "R4 idle snoop mailbox");
        stx(12'h123, 0, "R5 stx without reservation");

        // R3/R4 sweep: every snoop address against held 0x5A7.
        for (int s = 0; s < (1 << AW); s++) begin
            bit m;
            m = same_blk(s, 12'h5A7);
            ldx(12'h5A7);
            snp_valid = 1; snp_addr = AW'(s); tick();
            chk(wake_pulse, m, "R3 R4 snoop wake");
            chk(evt_mailbox, m, "R3 R4 snoop mailbox");
            evt_consume = 1;
            stx(12'h5A7, !m, "R3 R4 reservation after snoop");
            chk(wake_pulse, 0, "R3 wake one cycle");
            chk(evt_mailbox, 0, "R9 consume clears");
        end

        // R2/R5/R10 sweep: every store address against held 0x35C.
        for (int t = 0; t < (1 << AW); t++) begin
            ldx(12'h35C);
            stx(t, same_blk(t, 12'h35C), "R2 R5 block compare");
        end

        // R10: run of failures past the limit, then a success clears.
        for (int k = 0; k < LIMIT + 3; k++) stx(12'h010, 0, "R10 fail run");
        ldx(12'h010);
        stx(12'h01F, 1, "R10 success clears");

        // R6: second store without a new load fails.
        ldx(12'h7F0);
        stx(12'h7F0, 1, "R6 first stx");
        stx(12'h7F0, 0, "R6 second stx");

        // R7: swap passes with no reservation, and leaves a reservation intact.
        stx_swap = 1; stx_valid = 1; stx_addr = 12'hABC; tick();
        chk(stx_pass, 1, "R7 swap idle"); chk(stx_fwd, 1, "R7 swap fwd");
        consec = 0;
        ldx(12'h440);
        stx_swap = 1; stx_valid = 1; stx_addr = 12'h990; tick();
        chk(stx_pass, 1, "R7 swap armed");
        stx(12'h44F, 1, "R7 reservation untouched");

        // R8: snoop-hit breaks without compare, no wake.
        ldx(12'h220);
        snp_hit = 1; tick();
        chk(evt_mailbox, 1, "R8 mailbox"); chk(wake_pulse, 0, "R8 no wake");
        stx(12'h220, 0, "R8 reservation broken");

        // R9: mailbox holds over idle cycles; set beats consume.
        tick(); tick();
        chk(evt_mailbox, 1, "R9 sticky");
        snp_hit = 1; evt_consume = 1; tick();
        chk(evt_mailbox, 1, "R9 set wins");
        evt_consume = 1; tick();
        chk(evt_mailbox, 0, "R9 consume");

        // R11: load with matching snoop while disarmed -> armed, no wake.
        ldx_valid = 1; ldx_addr = 12'h600; snp_valid = 1; snp_addr = 12'h605; tick();
        chk(wake_pulse, 0, "R11 snoop vs old state");
        stx(12'h600, 1, "R11 load wins over snoop");
        // R11: armed at A, load B with snoop A -> wake, reservation at B.
        ldx(12'h600);
        ldx_valid = 1; ldx_addr = 12'h700; snp_valid = 1; snp_addr = 12'h600; tick();
        chk(wake_pulse, 1, "R11 snoop hits old");
        evt_consume = 1; tick();
        stx(12'h700, 1, "R11 new reservation");
        // R11: load and store together -> store judged on old state, load arms.
        ldx(12'h800);
        ldx_valid = 1; ldx_addr = 12'h900; stx_valid = 1; stx_addr = 12'h800; tick();
        chk(stx_pass, 1, "R11 stx old state");
        consec = 0;
        stx(12'h900, 1, "R11 load wins over stx");

        // R1: reset mid-operation clears mailbox and reservation.
        ldx(12'h100);
        snp_hit = 0; snp_valid = 1; snp_addr = 12'h100; tick();
        for (int k = 0; k < LIMIT + 2; k++) stx(12'h100, 0, "R1 prep fails");
        rst_n = 0; tick(); rst_n = 1;
        consec = 0;
        chk(evt_mailbox, 0, "R1 mailbox reset");
        chk(livelock_warn, 0, "R1 warn reset");
        stx(12'h100, 0, "R1 reservation reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule